// File: doc/BRIEF.md
# Card Host Interrupt Status Unit

This unit collects the event and level indications of a card host controller in byte-wide status registers. It combines them with per-bit enable masks into a single level interrupt line for the processor. The command engine, the data path and the DMA engine sit outside it. They present their completions and errors as one-cycle pulses. Each pulse sets a sticky status bit that holds until software writes a one to that bit position.

Write protect and both raw card-detect pins are shown live in the status byte. They are never latched, and writes do not touch them. A card-detect source selector picks one of the two pins and applies a polarity. The result is a live card-present bit. Its rising edge sets a sticky device-inserted event. Software reaches all registers through a byte-addressed port. Writes happen on the clock edge when `wr_en_i` is high. Reads are combinational from `addr_i`.

Top module: `card_irq_status`

## Requirements
- R1: After reset, every sticky bit, every mask bit and every configuration bit is zero, and `irq_o` is low.
- R2: A pulse on `cmd_evt_i[n]` sets bit n of the event byte at 0x29. Bit 0 is SDIO, 1 command done, 2 response timeout, 3 auto-stop, 4 data timeout, 5 response CRC, 6 read CRC and 7 write CRC. A pulse on `xfer_evt_i[0]` sets bit 4 (multi-block done) of the status byte at 0x28, and a pulse on `xfer_evt_i[1]` sets bit 5 (block done). Each set bit stays set until it is cleared.
- R3: Writing a byte to 0x28 or 0x29 clears exactly the sticky bits written as one. In 0x28 those are bits 4, 5 and 7. Bits written as zero keep their value.
- R4: If a set pulse and a clearing write hit the same bit in one cycle, the bit ends up set.
- R5: Byte 0x28 shows live levels that writes do not affect: bit 1 is `wp_i`, bit 2 is `cd_dat3_i` and bit 3 is `cd_gpi_i`. Bit 0 reads zero.
- R6: Byte 0x0D holds the configuration. Bit 4 selects active-high polarity, bit 5 selects the GPI pin as source, bit 6 selects the data3 pin and bit 7 is the global interrupt enable. Bits 3:0 read zero. Card present equals the selected pin (GPI has priority), inverted when bit 4 is zero. With no source selected, card present is zero. Bit 6 of 0x28 shows card present live.
- R7: A 0-to-1 change of card present sets the sticky device-inserted bit 7 of 0x28.
- R8: Mask bytes read back as written. At 0x24 only bits 7:4 are kept, each enabling the status bit of the same position in 0x28. At 0x25 only bits 7:1 are kept, each enabling the same bit of 0x29. Unkept bits read zero.
- R9: `irq_o` is high exactly when the global enable is set and some bit of 0x28 or 0x29 is set together with its mask bit. This includes the live card-present bit.
- R10: Reads of any other address return zero, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Combinational read data |
| xfer_evt_i | input | 2 | Transfer done pulses: bit 0 multi-block, bit 1 block |
| cmd_evt_i | input | 8 | Command and error pulses, aligned to 0x29 bits |
| wp_i | input | 1 | Write-protect level |
| cd_gpi_i | input | 1 | GPI card-detect pin level |
| cd_dat3_i | input | 1 | Data3 card-detect pin level |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a pulse landing in the same cycle as a write-one-to-clear of the same bit. The stimulus forces it directly and then floods a long random phase with overlapping pulses and writes. Card insertion is also hard to reach: it only exists as an edge of a derived level. The stimulus reaches it by reprogramming the source and polarity while the pins are held steady, and by toggling the pins under a fixed selection. A behavioural model computes the expected read value and interrupt level every clock.

// File: rtl/card_irq_status.sv
module card_irq_status #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] OFS_CFG   = 'h0D,
  parameter logic [ADDR_W-1:0] OFS_MASK0 = 'h24,
  parameter logic [ADDR_W-1:0] OFS_MASK1 = 'h25,
  parameter logic [ADDR_W-1:0] OFS_STS0  = 'h28,
  parameter logic [ADDR_W-1:0] OFS_STS1  = 'h29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  input  logic [1:0]        xfer_evt_i,
  input  logic [7:0]        cmd_evt_i,
  input  logic              wp_i,
  input  logic              cd_gpi_i,
  input  logic              cd_dat3_i,
  output logic              irq_o
);
  logic [2:0] sts0_q;
  logic [7:0] sts1_q;
  logic [3:0] msk0_q;
  logic [6:0] msk1_q;
  logic [3:0] cfg_q;
  logic       prev_q;
  logic       cd_lvl, cd_present;
  logic [7:0] sts0_view;

  wire wr_s0 = wr_en_i && (addr_i == OFS_STS0);
  wire wr_s1 = wr_en_i && (addr_i == OFS_STS1);
  wire wr_m0 = wr_en_i && (addr_i == OFS_MASK0);
  wire wr_m1 = wr_en_i && (addr_i == OFS_MASK1);
  wire wr_cf = wr_en_i && (addr_i == OFS_CFG);

  assign cd_lvl     = cfg_q[1] ? cd_gpi_i : cd_dat3_i;
  assign cd_present = (cfg_q[1] | cfg_q[2]) & (cfg_q[0] ? cd_lvl : ~cd_lvl);

  wire       ins_rise = cd_present & ~prev_q;
  wire [2:0] s0_clr   = wr_s0 ? {wr_data_i[7], wr_data_i[5], wr_data_i[4]} : 3'b000;
  wire [7:0] s1_clr   = wr_s1 ? wr_data_i : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts0_q <= '0;
      sts1_q <= '0;
      msk0_q <= '0;
      msk1_q <= '0;
      cfg_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      sts0_q <= (sts0_q & ~s0_clr) | {ins_rise, xfer_evt_i[1], xfer_evt_i[0]};
      sts1_q <= (sts1_q & ~s1_clr) | cmd_evt_i;
      prev_q <= cd_present;
      if (wr_m0) msk0_q <= wr_data_i[7:4];
      if (wr_m1) msk1_q <= wr_data_i[7:1];
      if (wr_cf) cfg_q  <= wr_data_i[7:4];
    end
  end

  assign sts0_view = {sts0_q[2], cd_present, sts0_q[1], sts0_q[0],
                      cd_gpi_i, cd_dat3_i, wp_i, 1'b0};

  always_comb begin
    unique case (addr_i)
      OFS_STS0:  rd_data_o = sts0_view;
      OFS_STS1:  rd_data_o = sts1_q;
      OFS_MASK0: rd_data_o = {msk0_q, 4'h0};
      OFS_MASK1: rd_data_o = {msk1_q, 1'b0};
      OFS_CFG:   rd_data_o = {cfg_q, 4'h0};
      default:   rd_data_o = 8'h00;
    endcase
  end

  assign irq_o = cfg_q[3] & ((|(sts0_view[7:4] & msk0_q)) | (|(sts1_q[7:1] & msk1_q)));
endmodule

module card_irq_status_chk #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] OFS_STS0 = 'h28,
  parameter logic [ADDR_W-1:0] OFS_STS1 = 'h29
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wr_data_i,
  input logic [7:0]        cmd_evt_i,
  input logic              wp_i,
  input logic [7:0]        rd_data_o,
  input logic              irq_o,
  input logic [7:0]        sts1_q,
  input logic [3:0]        cfg_q
);
  wire wr1 = wr_en_i && (addr_i == OFS_STS1);

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni) cmd_evt_i[1] |=> sts1_q[1]); // R2
  AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) (sts1_q[5] && !(wr1 && wr_data_i[5])) |=> sts1_q[5]); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni) (wr1 && wr_data_i[2] && !cmd_evt_i[2]) |=> !sts1_q[2]); // R3
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni) (wr1 && wr_data_i[3] && cmd_evt_i[3]) |=> sts1_q[3]); // R4
  AST_WP_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni) (addr_i == OFS_STS0) |-> (rd_data_o[1] == wp_i)); // R5
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk_i) disable iff (!rst_ni) irq_o |-> cfg_q[3]); // R9
endmodule

bind card_irq_status card_irq_status_chk #(
  .ADDR_W(ADDR_W), .OFS_STS0(OFS_STS0), .OFS_STS1(OFS_STS1)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wr_data_i(wr_data_i), .cmd_evt_i(cmd_evt_i), .wp_i(wp_i),
  .rd_data_o(rd_data_o), .irq_o(irq_o), .sts1_q(sts1_q), .cfg_q(cfg_q)
);

// File: tb/card_irq_status_tb.sv
module card_irq_status_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, we, wp, gpi, dat3;
  logic [5:0] addr;
  logic [7:0] wd, cmd;
  logic [1:0] xfer;
  wire  [7:0] rd;
  wire        irq;

  card_irq_status u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wr_data_i(wd),
    .rd_data_o(rd), .xfer_evt_i(xfer), .cmd_evt_i(cmd), .wp_i(wp),
    .cd_gpi_i(gpi), .cd_dat3_i(dat3), .irq_o(irq)
  );

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";
  logic [7:0] m_s0, m_s1, m_m0, m_m1;
  logic [3:0] m_cfg;
  logic       m_prev;

  function automatic logic present(input logic [3:0] c, input logic g, input logic d);
    if (c[1]) return c[0] ? g : !g;
    if (c[2]) return c[0] ? d : !d;
    return 1'b0;
  endfunction

  task automatic tick();
    logic p;
    logic [7:0] view0, exp_rd;
    logic exp_irq;
    @(negedge clk);
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_m0 = 0; m_m1 = 0; m_cfg = 0; m_prev = 0;
    end else begin
      p = present(m_cfg, gpi, dat3);
      if (we && addr == 6'h28) m_s0 = m_s0 & ~(wd & 8'hB0);
      if (we && addr == 6'h29) m_s1 = m_s1 & ~wd;
      if (p && !m_prev) m_s0[7] = 1'b1;
      if (xfer[0]) m_s0[4] = 1'b1;
      if (xfer[1]) m_s0[5] = 1'b1;
      m_s1 = m_s1 | cmd;
      m_prev = p;
      if (we && addr == 6'h24) m_m0 = wd & 8'hF0;
      if (we && addr == 6'h25) m_m1 = wd & 8'hFE;
      if (we && addr == 6'h0D) m_cfg = wd[7:4];
    end
    view0 = m_s0;
    view0[6] = present(m_cfg, gpi, dat3);
    view0[3] = gpi; view0[2] = dat3; view0[1] = wp;
    case (addr)
      6'h28: exp_rd = view0;
      6'h29: exp_rd = m_s1;
      6'h24: exp_rd = m_m0;
      6'h25: exp_rd = m_m1;
      6'h0D: exp_rd = {m_cfg, 4'h0};
      default: exp_rd = 8'h00;
    endcase
    exp_irq = m_cfg[3] && (((view0 & m_m0) != 0) || ((m_s1 & m_m1) != 0));
    vectors++;
    if (rd !== exp_rd) begin
      miscompares++;
      $display("FAIL %s addr=%h rd actual %h expected %h", tag, addr, rd, exp_rd);
    end
    vectors++;
    if (irq !== exp_irq) begin
      miscompares++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, exp_irq);
    end
  endtask

  task automatic cyc(input logic [5:0] a, input logic w, input logic [7:0] d,
                     input logic [1:0] x, input logic [7:0] c);
    addr = a; we = w; wd = d; xfer = x; cmd = c;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 0; we = 0; addr = 0; wd = 0; xfer = 0; cmd = 0; wp = 0; gpi = 0; dat3 = 0;
    tag = "R1";
    cyc(6'h28, 0, 0, 0, 0); cyc(6'h29, 0, 0, 0, 0); cyc(6'h24, 0, 0, 0, 0);
    cyc(6'h25, 0, 0, 0, 0); cyc(6'h0D, 0, 0, 0, 0);
    rst_n = 1;
    cyc(6'h29, 0, 0, 0, 0);

    tag = "R2";
    for (int i = 0; i < 8; i++) cyc(6'h29, 0, 0, 0, 8'(1 << i));
    cyc(6'h28, 0, 0, 2'b01, 0); cyc(6'h28, 0, 0, 2'b10, 0); cyc(6'h28, 0, 0, 0, 0);

    tag = "R3";
    cyc(6'h29, 1, 8'h04, 0, 0); cyc(6'h29, 0, 0, 0, 0);
    cyc(6'h28, 1, 8'h10, 0, 0); cyc(6'h28, 0, 0, 0, 0);

    tag = "R4";
    cyc(6'h29, 1, 8'h08, 0, 8'h08); cyc(6'h29, 0, 0, 0, 0);
    cyc(6'h28, 1, 8'h20, 2'b10, 0); cyc(6'h28, 0, 0, 0, 0);
    cyc(6'h29, 1, 8'hFF, 0, 0); cyc(6'h28, 1, 8'hFF, 0, 0);

    tag = "R5";
    wp = 1; cyc(6'h28, 1, 8'hFF, 0, 0);
    dat3 = 1; cyc(6'h28, 0, 0, 0, 0);
    gpi = 1; dat3 = 0; cyc(6'h28, 1, 8'h0E, 0, 0);
    wp = 0; cyc(6'h28, 0, 0, 0, 0);

    tag = "R6";
    gpi = 0; dat3 = 1;
    cyc(6'h0D, 1, 8'h2F, 0, 0); cyc(6'h28, 0, 0, 0, 0); cyc(6'h0D, 0, 0, 0, 0);
    cyc(6'h0D, 1, 8'h50, 0, 0); cyc(6'h28, 0, 0, 0, 0);
    cyc(6'h0D, 1, 8'h40, 0, 0); cyc(6'h28, 0, 0, 0, 0);
    cyc(6'h0D, 1, 8'h00, 0, 0); cyc(6'h28, 0, 0, 0, 0);
    cyc(6'h0D, 1, 8'h70, 0, 0); cyc(6'h28, 0, 0, 0, 0);

    tag = "R7";
    cyc(6'h28, 1, 8'hFF, 0, 0); cyc(6'h0D, 1, 8'h30, 0, 0); cyc(6'h28, 0, 0, 0, 0);
    gpi = 1; cyc(6'h28, 0, 0, 0, 0); cyc(6'h28, 0, 0, 0, 0);
    gpi = 0; cyc(6'h28, 0, 0, 0, 0);
    cyc(6'h28, 1, 8'h80, 0, 0); cyc(6'h28, 0, 0, 0, 0);

    tag = "R8";
    cyc(6'h24, 1, 8'hFF, 0, 0); cyc(6'h24, 0, 0, 0, 0);
    cyc(6'h25, 1, 8'hFF, 0, 0); cyc(6'h25, 0, 0, 0, 0);
    cyc(6'h24, 1, 8'h5A, 0, 0); cyc(6'h25, 1, 8'hA5, 0, 0); cyc(6'h25, 0, 0, 0, 0);
    cyc(6'h24, 1, 8'h00, 0, 0); cyc(6'h25, 1, 8'h00, 0, 0);

    tag = "R9";
    cyc(6'h0D, 1, 8'hB0, 0, 0); cyc(6'h25, 1, 8'h02, 0, 0);
    cyc(6'h29, 0, 0, 0, 8'h01); cyc(6'h29, 0, 0, 0, 8'h02); cyc(6'h29, 0, 0, 0, 0);
    cyc(6'h0D, 1, 8'h30, 0, 0); cyc(6'h0D, 1, 8'hB0, 0, 0);
    cyc(6'h29, 1, 8'h02, 0, 0); cyc(6'h24, 1, 8'h40, 0, 0);
    gpi = 1; cyc(6'h28, 0, 0, 0, 0); gpi = 0; cyc(6'h28, 0, 0, 0, 0);
    cyc(6'h24, 1, 8'h10, 0, 0); cyc(6'h28, 0, 0, 2'b01, 0); cyc(6'h28, 1, 8'h10, 0, 0);

    tag = "R10";
    cyc(6'h26, 1, 8'hFF, 0, 0); cyc(6'h0C, 1, 8'hFF, 0, 0); cyc(6'h3F, 1, 8'hFF, 0, 0);
    cyc(6'h26, 0, 0, 0, 0); cyc(6'h0C, 0, 0, 0, 0); cyc(6'h0D, 0, 0, 0, 0);
    cyc(6'h24, 0, 0, 0, 0);

    tag = "R9";
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] a;
      logic [7:0] c;
      case ($urandom_range(0, 6))
        0: a = 6'h24; 1: a = 6'h25; 2: a = 6'h28; 3: a = 6'h29;
        4: a = 6'h0D; 5: a = 6'h0C; default: a = 6'($urandom);
      endcase
      c = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      if ($urandom_range(0, 15) == 0) wp = ~wp;
      if ($urandom_range(0, 9) == 0) gpi = ~gpi;
      if ($urandom_range(0, 9) == 0) dat3 = ~dat3;
      cyc(a, $urandom_range(0, 9) < 3, 8'($urandom), 2'($urandom_range(0, 3)), c);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule